// File: doc/BRIEF.md
# Receive Destination Address Filter

The block sits beside a receive datapath and decides, for each incoming frame, whether it is kept or dropped. The decision depends only on the 48-bit destination address. The six address bytes arrive one per valid cycle, first byte first. A start flag marks the first byte. An end strobe is raised together with the last address byte. One cycle after that byte the block gives a single decision, a valid pulse with an accept bit.

Four rules decide the outcome. A unicast address is kept only when it equals the programmed station address. The all-ones broadcast address is kept unless broadcast rejection is turned on. Any other group address is kept when its bin is set in a 64-bin hash table. The bin is chosen by six bits of a CRC32 that runs alongside the incoming bytes. Promiscuous mode keeps every complete address. A simple write port loads the station address, the two hash words and the two control bits.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, dec_valid_o and dec_accept_o are 0. All configuration is zero: the station address is 00:00:00:00:00:00, every hash bin is clear, and broadcast rejection and promiscuous mode are both off.
- R2: dec_valid_o is 1 for exactly the cycle that follows a clock edge sampling byte_valid_i=1 together with addr_end_i=1, and 0 at every other time. dec_accept_o is never 1 while dec_valid_o is 0.
- R3: A byte sampled with sof_i=1 becomes address byte 0. Later valid bytes fill bytes 1 to 5, and bytes beyond the sixth are ignored. If the end strobe does not arrive with the sixth byte, the decision is a reject, even in promiscuous mode. An end strobe without byte_valid_i is ignored.
- R4: An address whose byte 0 has bit 0 clear is accepted only if all six bytes equal the station address. Station select 1 holds byte 0 in data bits 15:8 and byte 1 in bits 7:0. Station select 0 holds bytes 2, 3, 4 and 5 in bits 31:24, 23:16, 15:8 and 7:0.
- R5: The all-ones address is accepted while control bit 0 (reject broadcast) is 0, and rejected while it is 1.
- R6: For any other address with bit 0 of byte 0 set, the hash index is taken from a CRC32. The CRC starts at all ones, is updated byte by byte with bits taken LSB first using the reflected polynomial 0xEDB88320, and has no final complement. The index is bits 31:26 of the CRC. Index bit 5 selects the hash word (0 = select 2, 1 = select 3), and index bits 4:0 select the bit within that word. The frame is accepted when that bit is 1.
- R7: With both hash words all ones, every non-broadcast group address is accepted.
- R8: With control bit 1 (promiscuous) set, every complete address is accepted. This includes broadcast while broadcast rejection is on.
- R9: A write takes effect when wr_en_i=1, with wr_sel_i selecting the target: 0 station low, 1 station high, 2 hash low, 3 hash high, 4 control. Select values 5 to 7, and any cycle with wr_en_i=0, leave the configuration unchanged.
- R10: A decision uses the configuration held before the edge that samples the last address byte. A write in that same cycle affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_sel_i | input | 3 | Configuration target select |
| wr_data_i | input | 32 | Configuration write data |
| byte_valid_i | input | 1 | Address byte present on byte_i |
| byte_i | input | 8 | Destination address byte |
| sof_i | input | 1 | Current byte is address byte 0 |
| addr_end_i | input | 1 | Current byte is the last address byte |
| dec_valid_o | output | 1 | Decision pulse |
| dec_accept_o | output | 1 | Frame accepted (meaningful with dec_valid_o) |

## Verification
Faults in the internal state show up at the ports quickly. A wrong byte counter or a wrong byte slot corrupts the assembled address. That appears in the very next decision, as a false reject of a matching station address or as a false accept after a short or over-long address. A wrong CRC seed or step, or the wrong hash word being selected, sends a group address to the wrong bin. It is exposed on the first frame whose single programmed bin differs from the wrong one. A write decoded to the wrong register changes the accept result of the following frame. The bench probes each path with directed addresses and with randomised configurations mixed with randomised frames.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int BYTE_W     = 8;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam int REG_W      = 32;
  localparam int HASH_IDX_W = 6;
  localparam int HASH_BINS  = 2 ** HASH_IDX_W;
  localparam int HASH_WORDS = HASH_BINS / REG_W;
  localparam int SEL_W      = 3;
  localparam int CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;

  localparam logic [SEL_W-1:0] SEL_STA_LO    = 3'd0;
  localparam logic [SEL_W-1:0] SEL_STA_HI    = 3'd1;
  localparam int               SEL_HASH_BASE = 2;
  localparam logic [SEL_W-1:0] SEL_CTRL      = 3'd4;

  localparam int CTRL_REJ_BCAST = 0;
  localparam int CTRL_PROMISC   = 1;

  typedef struct packed {
    logic [ADDR_BYTES-1:0][BYTE_W-1:0] station;
    logic [HASH_BINS-1:0]              hash;
    logic                              rej_bcast;
    logic                              promisc;
  } filt_cfg_t;

  // one byte, LSB first, reflected form
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] c;
    c = c_in ^ {{(CRC_W-BYTE_W){1'b0}}, b};
    for (int k = 0; k < BYTE_W; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int HW = HASH_WORDS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [RW-1:0]    wr_data_i,
  output filt_cfg_t        cfg_o
);
  localparam int HI_W = 2 * BYTE_W;
  localparam int LO_BYTES = ADDR_BYTES - 2;

  logic [RW-1:0]    sta_lo_q;
  logic [HI_W-1:0]  sta_hi_q;
  logic [RW-1:0]    hash_q [HW];
  logic [HW*RW-1:0] hash_flat;
  logic             rej_q, pro_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sta_lo_q <= '0;
      sta_hi_q <= '0;
      rej_q    <= 1'b0;
      pro_q    <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_STA_LO) sta_lo_q <= wr_data_i;
      if (wr_sel_i == SEL_STA_HI) sta_hi_q <= wr_data_i[HI_W-1:0];
      if (wr_sel_i == SEL_CTRL) begin
        rej_q <= wr_data_i[CTRL_REJ_BCAST];
        pro_q <= wr_data_i[CTRL_PROMISC];
      end
    end
  end

  for (genvar w = 0; w < HW; w++) begin : g_hash
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(SEL_HASH_BASE + w);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            hash_q[w] <= '0;
      else if (wr_en_i && wr_sel_i == MY_SEL) hash_q[w] <= wr_data_i;
    end
    assign hash_flat[w*RW +: RW] = hash_q[w];
  end

  always_comb begin
    cfg_o.station[0] = sta_hi_q[HI_W-1 -: BYTE_W];
    cfg_o.station[1] = sta_hi_q[BYTE_W-1:0];
    for (int k = 0; k < LO_BYTES; k++) begin
      cfg_o.station[2+k] = sta_lo_q[RW-1-BYTE_W*k -: BYTE_W];
    end
    cfg_o.hash      = hash_flat;
    cfg_o.rej_bcast = rej_q;
    cfg_o.promisc   = pro_q;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_o)); // R9
  AST_BAD_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i > SEL_CTRL) |=> $stable(cfg_o)); // R9
endmodule

// File: rtl/rxf_addr_shift.sv
module rxf_addr_shift
  import rxf_pkg::*;
#(
  parameter int NB = ADDR_BYTES,
  parameter int BW = BYTE_W,
  parameter int CW = CNT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    byte_valid_i,
  input  logic [BW-1:0]           byte_i,
  input  logic                    sof_i,
  input  logic                    addr_end_i,
  output logic                    take_o,
  output logic                    complete_o,
  output logic [NB-1:0][BW-1:0]   addr_nxt_o
);
  logic [CW-1:0]         cnt_q, cnt_d, slot;
  logic [NB-1:0][BW-1:0] addr_q;
  logic                  room;

  assign slot   = sof_i ? '0 : cnt_q;
  assign room   = sof_i || (cnt_q < CW'(NB));
  assign take_o = byte_valid_i && room;
  assign complete_o = take_o && addr_end_i && (slot == CW'(NB - 1));

  always_comb begin
    addr_nxt_o = addr_q;
    if (take_o) addr_nxt_o[slot] = byte_i;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (byte_valid_i && addr_end_i) cnt_d = '0;
    else if (take_o)                cnt_d = slot + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      addr_q <= addr_nxt_o;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(NB)); // R3
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && addr_end_i) |=> cnt_q == '0); // R3
  AST_SOF_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && sof_i && !addr_end_i) |=> cnt_q == CW'(1)); // R3
endmodule

// File: rtl/rxf_crc_byte.sv
module rxf_crc_byte
  import rxf_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int CRCW = CRC_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            restart_i,
  input  logic [BW-1:0]   byte_i,
  output logic [CRCW-1:0] crc_nxt_o
);
  logic [CRCW-1:0] crc_q, seed;

  assign seed      = restart_i ? '1 : crc_q;
  assign crc_nxt_o = take_i ? crc_step(seed, byte_i) : crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '1;
    else         crc_q <= crc_nxt_o;
  end

  AST_CRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(crc_q)); // R6
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [SEL_W-1:0]      wr_sel_i,
  input  logic [REG_W-1:0]      wr_data_i,
  input  logic                  byte_valid_i,
  input  logic [BYTE_W-1:0]     byte_i,
  input  logic                  sof_i,
  input  logic                  addr_end_i,
  output logic                  dec_valid_o,
  output logic                  dec_accept_o
);
  filt_cfg_t                         cfg;
  logic                              take, complete, end_c;
  logic [ADDR_BYTES-1:0][BYTE_W-1:0] addr_nxt;
  logic [CRC_W-1:0]                  crc_nxt;
  logic [HASH_IDX_W-1:0]             hidx;
  logic                              is_bcast, is_group, is_match, hash_hit, accept_c;
  logic                              valid_q, accept_q;

  rxf_cfg_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .cfg_o(cfg)
  );

  rxf_addr_shift u_shift (
    .clk_i, .rst_ni, .byte_valid_i, .byte_i, .sof_i, .addr_end_i,
    .take_o(take), .complete_o(complete), .addr_nxt_o(addr_nxt)
  );

  rxf_crc_byte u_crc (
    .clk_i, .rst_ni, .take_i(take), .restart_i(sof_i), .byte_i,
    .crc_nxt_o(crc_nxt)
  );

  assign end_c    = byte_valid_i && addr_end_i;
  assign hidx     = crc_nxt[CRC_W-1 -: HASH_IDX_W];
  assign is_bcast = &addr_nxt;
  assign is_group = addr_nxt[0][0];
  assign is_match = (addr_nxt == cfg.station);
  assign hash_hit = cfg.hash[hidx];

  // priority: promiscuous, broadcast, group hash, station match
  always_comb begin
    accept_c = 1'b0;
    if (complete) begin
      if (cfg.promisc)    accept_c = 1'b1;
      else if (is_bcast)  accept_c = !cfg.rej_bcast;
      else if (is_group)  accept_c = hash_hit;
      else                accept_c = is_match;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      valid_q  <= end_c;
      accept_q <= accept_c;
    end
  end

  assign dec_valid_o  = valid_q;
  assign dec_accept_o = accept_q;

  AST_VALID_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_c |=> dec_valid_o); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_c |=> !dec_valid_o); // R2
  AST_ACCEPT_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_accept_o |-> dec_valid_o); // R2
  AST_SHORT_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_c && !complete) |=> !dec_accept_o); // R3
  AST_PROMISC_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (complete && cfg.promisc) |=> dec_accept_o); // R8
  AST_BCAST_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (complete && is_bcast && cfg.rej_bcast && !cfg.promisc) |=> !dec_accept_o); // R5
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_d = '0;
  logic        sof = 1'b0;
  logic        addr_end = 1'b0;
  logic        dec_valid, dec_accept;

  always #10 clk = ~clk;

  rx_addr_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .byte_valid_i(byte_valid), .byte_i(byte_d),
    .sof_i(sof), .addr_end_i(addr_end), .dec_valid_o(dec_valid),
    .dec_accept_o(dec_accept)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_lo = '0, m_hi = '0, m_hlo = '0, m_hhi = '0;
  logic        m_rej = 1'b0, m_pro = 1'b0;

  function automatic logic [31:0] b_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      c ^= {24'h0, a[8*i +: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic b_exp(input logic [47:0] a, input int n);
    logic [47:0] st;
    logic [63:0] h;
    logic [31:0] c;
    if (n != 6) return 1'b0;
    if (m_pro) return 1'b1;
    if (a == '1) return !m_rej;
    if (a[0]) begin
      h = {m_hhi, m_hlo};
      c = b_crc(a);
      return h[c[31:26]];
    end
    st = {m_lo[7:0], m_lo[15:8], m_lo[23:16], m_lo[31:24], m_hi[7:0], m_hi[15:8]};
    return a == st;
  endfunction

  function automatic void model_wr(input logic [2:0] s, input logic [31:0] d);
    case (s)
      3'd0: m_lo = d;
      3'd1: m_hi = {16'h0, d[15:0]};
      3'd2: m_hlo = d;
      3'd3: m_hhi = d;
      3'd4: begin m_rej = d[0]; m_pro = d[1]; end
      default: ;
    endcase
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(s, d);
  endtask

  task automatic send(input logic [47:0] a, input int n, input bit do_wr,
                      input logic [2:0] ws, input logic [31:0] wd, input string req);
    logic e;
    e = b_exp(a, n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_valid = 1'b1;
      byte_d     = (i < 6) ? a[8*i +: 8] : 8'($urandom);
      sof        = (i == 0);
      addr_end   = (i == n - 1);
      if (do_wr && i == n - 1) begin
        wr_en = 1'b1; wr_sel = ws; wr_data = wd;
      end
    end
    @(negedge clk);
    byte_valid = 1'b0; sof = 1'b0; addr_end = 1'b0; wr_en = 1'b0;
    if (do_wr) model_wr(ws, wd);
    chk({"R2 valid after end (", req, ")"}, dec_valid, 1'b1);
    chk(req, dec_accept, e);
    @(negedge clk);
    chk("R2 valid single cycle", dec_valid, 1'b0);
  endtask

  task automatic frame(input logic [47:0] a, input string req);
    send(a, 6, 1'b0, 3'd0, 32'd0, req);
  endtask

  function automatic logic [47:0] rnd_addr();
    return {16'($urandom), $urandom};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] a;
    logic [63:0] h;
    logic [5:0]  idx;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 reset valid", dec_valid, 1'b0);
    chk("R1 reset accept", dec_accept, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle valid", dec_valid, 1'b0);

    // R1: zero configuration behaviour
    frame(48'hFFFF_FFFF_FFFF, "R1 broadcast at reset config");
    frame(48'h0, "R1 zero station matches zero address");
    frame(48'h0000_0000_0001, "R1 group address with empty hash");

    // R4: station match; byte0=02 byte1=11 byte2=22 .. byte5=55
    wr(3'd1, 32'hABCD_0211);
    wr(3'd0, 32'h2233_4455);
    frame(48'h5544_3322_1102, "R4 exact station match");
    frame(48'h5644_3322_1102, "R4 last byte differs");
    frame(48'h5544_3322_1104, "R4 first byte differs");
    frame(48'h5544_3322_0211, "R4 byte order swapped");

    // R5
    frame(48'hFFFF_FFFF_FFFF, "R5 broadcast accepted");
    wr(3'd4, 32'h1);
    frame(48'hFFFF_FFFF_FFFF, "R5 broadcast rejected");

    // R9: ignored writes observed through broadcast result
    @(negedge clk); wr_en = 1'b0; wr_sel = 3'd4; wr_data = 32'h0;
    @(negedge clk);
    frame(48'hFFFF_FFFF_FFFF, "R9 write without enable ignored");
    for (int s = 5; s < 8; s++) begin
      wr(3'(s), 32'hFFFF_FFFF);
      frame(48'hFFFF_FFFF_FFFF, "R9 unused select ignored");
      frame(48'h5544_3322_1102, "R9 unused select keeps station");
    end

    // R6: single hash bin
    a   = 48'h0100_5E00_0001;
    idx = b_crc(a)[31:26];
    h = 64'd1 << idx;
    wr(3'd2, h[31:0]); wr(3'd3, h[63:32]);
    frame(a, "R6 matching hash bin");
    h = 64'd1 << (idx ^ 6'd32);
    wr(3'd2, h[31:0]); wr(3'd3, h[63:32]);
    frame(a, "R6 same bit in other word");
    h = 64'd1 << (idx ^ 6'd1);
    wr(3'd2, h[31:0]); wr(3'd3, h[63:32]);
    frame(a, "R6 neighbouring bin");

    // R7
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
    for (int i = 0; i < 20; i++) begin
      a = rnd_addr(); a[0] = 1'b1; a[47] = 1'b0;
      frame(a, "R7 all-ones hash accepts group");
    end

    // R8
    wr(3'd4, 32'h3);
    frame(48'hFFFF_FFFF_FFFF, "R8 promiscuous broadcast with reject on");
    frame(48'h1234_5678_9A00, "R8 promiscuous foreign unicast");

    // R3: short, long, stray end, restart
    send(48'h5544_3322_1102, 5, 1'b0, 3'd0, 32'd0, "R3 short address rejected");
    send(48'h5544_3322_1102, 7, 1'b0, 3'd0, 32'd0, "R3 long address rejected");
    @(negedge clk); addr_end = 1'b1;
    @(negedge clk); addr_end = 1'b0;
    chk("R3 end strobe without byte ignored", dec_valid, 1'b0);
    wr(3'd4, 32'h0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); byte_valid = 1'b1; byte_d = 8'hEE; sof = (i == 0);
    end
    frame(48'h5544_3322_1102, "R3 start flag restarts address");

    // R10: write in the last-byte cycle
    send(48'h5544_3322_1102, 6, 1'b1, 3'd0, 32'h0, "R10 old station used");
    frame(48'h5544_3322_1102, "R10 new station used");
    send(48'h0000_0000_1234, 6, 1'b1, 3'd4, 32'h2, "R10 promisc not yet active");
    frame(48'h0000_0000_1234, "R10 promisc now active");

    // random configurations and frames
    for (int i = 0; i < 400; i++) begin
      int kind;
      if (i % 25 == 0) begin
        wr(3'd0, $urandom); wr(3'd1, $urandom);
        wr(3'd2, $urandom); wr(3'd3, $urandom);
        wr(3'd4, {30'd0, ($urandom % 4 == 0), 1'($urandom)});
      end
      kind = $urandom % 4;
      case (kind)
        0: a = rnd_addr() & ~48'h1;
        1: a = {m_lo[7:0], m_lo[15:8], m_lo[23:16], m_lo[31:24], m_hi[7:0], m_hi[15:8]};
        2: a = '1;
        default: a = rnd_addr() | 48'h1;
      endcase
      if ($urandom % 10 == 0)
        send(a, 5 + 2 * ($urandom % 2), 1'b0, 3'd0, 32'd0, "R3 random length");
      else if (kind == 3)
        frame(a, "R6 random group");
      else if (kind == 2)
        frame(a, "R5 random broadcast");
      else
        frame(a, "R4 random unicast");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule